// File: doc/BRIEF.md
# UART Status and Flow-Control Unit

This block holds the status and handshake logic that sits around a byte-wide UART able to drive a single-wire LIN bus. Software loads a one-byte transmit holding register through a small register port. The block moves that byte into a shift register when the line is free and the clear-to-send condition allows. It then sends a frame of one start bit, the data bits least significant first, and one stop bit, one bit per `bit_tick` strobe.

Bytes from the receive deserializer come in on a strobed interface and are kept in a receive register. While a character is going out, each bit read back from the bus at the mid-bit strobe is compared with the bit being driven. A difference is recorded as a physical-layer error, which shows that another node drove the line or that the transceiver is at fault. All event flags are gathered in one read-only status byte and are cleared by reads. If a flag is set and cleared in the same cycle, the set wins.

Register map (2-bit address, read data registered one cycle after `reg_rd`): 0 = transmit data on write, receive data on read; 1 = status (read-only); 2 = control, with bit 0 loopback enable, bit 1 clear-to-send enable, and bit 7 read-only effective clear-to-send level.

Top module: `uart_stat_flow`

## Requirements
- R1: After reset the status byte reads 0x06, with bit 2 transmit-holding-empty and bit 1 transmitter-empty both 1 and every other bit 0. The serial output is 1 and the control register reads 0.
- R2: A write to address 0 clears status bit 2. The bit sets again in the cycle after the byte is copied into the shift register.
- R3: Status bit 1 reads 0 from the cycle a character starts until its tenth `bit_tick`. The serial output goes through start 0, the data bits LSB first, and stop 1, advancing one bit per tick. It is 1 while idle.
- R4: An arriving byte sets status bit 7. A read of address 0 returns the byte and clears bit 7.
- R5: A byte arriving while bit 7 is 1 and no data read is under way sets overrun (bit 5) and keeps the old byte. A status read clears overrun.
- R6: If a flag is set in the same cycle as a read that would clear it, the flag stays set. A receive byte that arrives together with a data read is stored, and it does not count as overrun.
- R7: Physical-layer error (bit 6) sets when `rx_sample` is high, a character is being sent, and `rxd` differs from `txd`. It stays 0 while idle. A status read or a data read clears it.
- R8: With control bit 1 at 0 a character starts whatever the clear-to-send level is. With control bit 1 at 1 a character waits until the effective clear-to-send level is 1.
- R9: Control bit 7 reads the effective clear-to-send level. That level is `cts_in` when control bit 0 is 0, and status bit 7 (receive data available) when control bit 0 is 1.
- R10: A byte stored with `rx_ferr` high sets framing error (bit 4). A status read clears it. Status bits 3 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| cts_in | input | 1 | External clear-to-send level, 1 = clear |
| rx_valid | input | 1 | Received byte strobe from deserializer |
| rx_data | input | DATA_W | Received byte |
| rx_ferr | input | 1 | Framing error flag for the received byte |
| rx_sample | input | 1 | Mid-bit sample strobe for bus readback |
| rxd | input | 1 | Bus level read back |
| bit_tick | input | 1 | One pulse per bit time for the transmitter |
| txd | output | 1 | Serial transmit output |

## Verification
A wrong internal state in this block shows up at the ports quickly. A stuck or stale flag corrupts the very next status or data read, one cycle after `reg_rd`. A mis-sequenced shift register changes `txd` at the tick after the faulty bit. A bad gating decision changes whether bit 1 drops in the cycle after the byte is loaded. The checks therefore read status right after each event and compare `txd` on every tick. They also cover same-cycle races between reads and arriving bytes, because that is where a priority error would hide.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int REG_W = 8;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  // control register bit positions
  localparam int C_LOOP = 0;
  localparam int C_CTSE = 1;
  localparam int C_CTSL = 7;
endpackage

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              bit_tick,
  input  logic              cts_ok,
  output logic              hold_empty,
  output logic              busy,
  output logic              ser_out
);
  localparam int FRAME = DATA_W + 2;
  localparam int CW    = $clog2(FRAME + 1);

  logic [DATA_W-1:0] hold_q;
  logic [FRAME-1:0]  shreg;
  logic [CW-1:0]     left;
  logic              start;

  assign start   = !hold_empty && !busy && cts_ok;
  assign ser_out = shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      hold_empty <= 1'b1;
      busy       <= 1'b0;
      shreg      <= '1;
      left       <= '0;
    end else begin
      if (start) begin
        shreg      <= {1'b1, hold_q, 1'b0};
        left       <= CW'(FRAME);
        busy       <= 1'b1;
        hold_empty <= 1'b1;
      end else if (busy && bit_tick) begin
        if (left == CW'(1)) begin
          busy  <= 1'b0;
          shreg <= '1;
          left  <= '0;
        end else begin
          shreg <= {1'b1, shreg[FRAME-1:1]};
          left  <= left - CW'(1);
        end
      end
      // a new write wins over the transfer of the previous byte
      if (load) begin
        hold_q     <= load_data;
        hold_empty <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ferr,
  input  logic              data_rd,
  input  logic              stat_rd,
  input  logic              mismatch,
  output logic              rda,
  output logic              oe,
  output logic              fe,
  output logic              ple,
  output logic [DATA_W-1:0] rx_hold
);
  logic accept;
  logic overrun;

  assign accept  = rx_valid && (!rda || data_rd);
  assign overrun = rx_valid && rda && !data_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rda     <= 1'b0;
      oe      <= 1'b0;
      fe      <= 1'b0;
      ple     <= 1'b0;
      rx_hold <= '0;
    end else begin
      if (accept)       rx_hold <= rx_data;

      if (accept)       rda <= 1'b1;
      else if (data_rd) rda <= 1'b0;

      if (overrun)      oe <= 1'b1;
      else if (stat_rd) oe <= 1'b0;

      if (accept && rx_ferr) fe <= 1'b1;
      else if (stat_rd)      fe <= 1'b0;

      if (mismatch)                ple <= 1'b1;
      else if (stat_rd || data_rd) ple <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_stat_flow.sv
module uart_stat_flow
  import uart_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              cts_in,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ferr,
  input  logic              rx_sample,
  input  logic              rxd,
  input  logic              bit_tick,
  output logic              txd
);
  logic              loop_en, cts_en, cts_eff, cts_ok;
  logic              data_wr, data_rd, stat_rd;
  logic              tdre, busy, txe, mismatch;
  logic              rda, oe, fe, ple;
  logic [DATA_W-1:0] rx_hold;
  logic [REG_W-1:0]  status, ctrl_view;

  assign data_wr  = reg_wr && (reg_addr == A_DATA);
  assign data_rd  = reg_rd && (reg_addr == A_DATA);
  assign stat_rd  = reg_rd && (reg_addr == A_STAT);
  assign cts_eff  = loop_en ? rda : cts_in;
  assign cts_ok   = !cts_en || cts_eff;
  assign txe      = !busy;
  assign mismatch = rx_sample && busy && (rxd != txd);

  always_ff @(posedge clk) begin
    if (rst) begin
      loop_en <= 1'b0;
      cts_en  <= 1'b0;
    end else if (reg_wr && reg_addr == A_CTRL) begin
      loop_en <= reg_wdata[C_LOOP];
      cts_en  <= reg_wdata[C_CTSE];
    end
  end

  uart_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .load(data_wr), .load_data(reg_wdata[DATA_W-1:0]),
    .bit_tick(bit_tick), .cts_ok(cts_ok), .hold_empty(tdre), .busy(busy),
    .ser_out(txd)
  );

  uart_rx_status #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ferr(rx_ferr), .data_rd(data_rd), .stat_rd(stat_rd),
    .mismatch(mismatch), .rda(rda), .oe(oe), .fe(fe), .ple(ple),
    .rx_hold(rx_hold)
  );

  always_comb begin
    status    = {rda, ple, oe, fe, 1'b0, tdre, txe, 1'b0};
    ctrl_view = '0;
    ctrl_view[C_CTSL] = cts_eff;
    ctrl_view[C_CTSE] = cts_en;
    ctrl_view[C_LOOP] = loop_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        A_DATA:  reg_rdata <= REG_W'(rx_hold);
        A_STAT:  reg_rdata <= status;
        A_CTRL:  reg_rdata <= ctrl_view;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_stat_flow_chk.sv
module uart_stat_flow_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic              tdre,
  input logic              txe,
  input logic              txd,
  input logic              rx_valid,
  input logic              rda,
  input logic              data_rd,
  input logic [DATA_W-1:0] rx_hold,
  input logic              oe,
  input logic              ple,
  input logic              cts_en,
  input logic              cts_eff
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (tdre && txe && !rda && !oe && !ple && txd));

  a_r2_write_clears_empty: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0) |=> !tdre);

  a_r3_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    txe |-> txd);

  a_r4_byte_sets_rda: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> rda);

  a_r5_overrun_keeps_old: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rda && !data_rd) |=> (oe && $stable(rx_hold)));

  a_r7_no_error_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!ple && txe) |=> !ple);

  a_r8_cts_holds_start: assert property (@(posedge clk) disable iff (rst)
    (cts_en && !cts_eff && txe) |=> txe);
endmodule

bind uart_stat_flow uart_stat_flow_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .tdre(tdre),
  .txe(txe), .txd(txd), .rx_valid(rx_valid), .rda(rda), .data_rd(data_rd),
  .rx_hold(rx_hold), .oe(oe), .ple(ple), .cts_en(cts_en), .cts_eff(cts_eff)
);

// File: tb/uart_stat_flow_test.sv
module uart_stat_flow_test;
  localparam int CLK_P = 10;
  localparam int NV = 5;
  // each entry: {byte, clear-to-send enable, clear-to-send level}
  localparam logic [9:0] TXV [NV] = '{
    {8'hA5, 1'b0, 1'b0}, {8'h3C, 1'b1, 1'b1}, {8'h01, 1'b1, 1'b0},
    {8'h80, 1'b0, 1'b1}, {8'hFE, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic cts_in = 0, rx_valid = 0, rx_ferr = 0, rx_sample = 0, bit_tick = 0;
  logic [7:0] rx_data = 0;
  logic flip = 0, txd, rxd;
  int total = 0, failed = 0;
  bit done = 0;

  assign rxd = txd ^ flip;
  always #(CLK_P/2) clk = ~clk;

  uart_stat_flow uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cts_in(cts_in),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
    .rx_sample(rx_sample), .rxd(rxd), .bit_tick(bit_tick), .txd(txd)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_rd = 1; reg_addr = a; step(); reg_rd = 0; v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; step(); reg_wr = 0;
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic fe);
    rx_valid = 1; rx_data = d; rx_ferr = fe; step(); rx_valid = 0; rx_ferr = 0;
  endtask

  task automatic tick();
    bit_tick = 1; step(); bit_tick = 0;
  endtask

  // sends an already started character, checking every bit
  task automatic drain(input logic [7:0] d, input string tag);
    logic [9:0] frame;
    frame = {1'b1, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      chk(tag, {7'd0, txd}, {7'd0, frame[i]});
      tick();
    end
    chk(tag, {7'd0, txd}, 8'h01);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    step(); step(); rst = 0; step();

    // R1 reset state
    rd(2'd1, v); chk("R1 status", v, 8'h06);
    rd(2'd2, v); chk("R1 control", v, 8'h00);
    chk("R1 txd idle", {7'd0, txd}, 8'h01);

    // vector table: R2 R3 R8
    for (int k = 0; k < NV; k++) begin
      logic [7:0] b;
      b = TXV[k][9:2];
      cts_in = TXV[k][0];
      wr(2'd2, {6'd0, TXV[k][1], 1'b0});
      wr(2'd0, b);
      rd(2'd1, v); chk("R2 empty cleared", v, 8'h02);
      rd(2'd1, v);
      if (TXV[k][1] && !TXV[k][0]) begin
        chk("R8 held by cts", v, 8'h02);
        cts_in = 1; step();
        rd(2'd1, v);
      end
      chk("R2 R3 R8 started", v, 8'h04);
      drain(b, "R3 frame bit");
      rd(2'd1, v); chk("R3 done", v, 8'h06);
    end
    wr(2'd2, 8'h00);

    // R4 receive
    rx_byte(8'h5A, 0);
    rd(2'd1, v); chk("R4 rda set", v, 8'h86);
    rd(2'd0, v); chk("R4 data", v, 8'h5A);
    rd(2'd1, v); chk("R4 rda cleared", v, 8'h06);

    // R5 overrun
    rx_byte(8'h11, 0); rx_byte(8'h22, 0);
    rd(2'd1, v); chk("R5 overrun", v, 8'hA6);
    rd(2'd1, v); chk("R5 overrun cleared", v, 8'h86);
    rd(2'd0, v); chk("R5 old byte kept", v, 8'h11);

    // R10 framing error
    rx_byte(8'h77, 1);
    rd(2'd1, v); chk("R10 framing", v, 8'h96);
    rd(2'd1, v); chk("R10 framing cleared", v, 8'h86);
    rd(2'd0, v); chk("R10 data", v, 8'h77);

    // R6 set beats clear
    rx_byte(8'h33, 0);
    rx_valid = 1; rx_data = 8'h44;
    rd(2'd0, v); rx_valid = 0;
    chk("R6 data read returns old", v, 8'h33);
    rd(2'd1, v); chk("R6 rda kept no overrun", v, 8'h86);
    rx_valid = 1; rx_data = 8'h55;
    rd(2'd1, v); rx_valid = 0;
    chk("R6 status before overrun", v, 8'h86);
    rd(2'd1, v); chk("R6 overrun survives read", v, 8'hA6);
    rd(2'd0, v); chk("R6 second byte", v, 8'h44);

    // R7 physical-layer error
    flip = 1; rx_sample = 1; step(); rx_sample = 0; flip = 0;
    rd(2'd1, v); chk("R7 idle ignored", v, 8'h06);
    wr(2'd0, 8'hC3); step();
    flip = 1; rx_sample = 1; step(); rx_sample = 0; flip = 0;
    rd(2'd1, v); chk("R7 mismatch", v, 8'h44);
    rd(2'd1, v); chk("R7 cleared by status", v, 8'h04);
    flip = 1; rx_sample = 1; step(); rx_sample = 0; flip = 0;
    rd(2'd0, v);
    rd(2'd1, v); chk("R7 cleared by data read", v, 8'h04);
    rx_sample = 1; step(); rx_sample = 0;
    rd(2'd1, v); chk("R7 match no error", v, 8'h04);
    drain(8'hC3, "R7 frame");

    // R9 effective clear-to-send
    cts_in = 1; rd(2'd2, v); chk("R9 cts level", v, 8'h80);
    cts_in = 0; rd(2'd2, v); chk("R9 cts low", v, 8'h00);
    cts_in = 1; wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R9 loopback uses rda", v, 8'h01);
    rx_byte(8'h99, 0);
    rd(2'd2, v); chk("R9 loopback rda high", v, 8'h81);
    rd(2'd0, v);
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h5C);
    rd(2'd1, v); rd(2'd1, v); chk("R9 R8 loopback hold", v, 8'h02);
    rx_byte(8'h12, 0); step();
    rd(2'd1, v); chk("R9 R8 loopback start", v, 8'h84);
    drain(8'h5C, "R9 frame");
    rd(2'd0, v); chk("R9 data", v, 8'h12);
    wr(2'd2, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule